// File: doc/BRIEF.md
# Compact Accumulator Node Core

This block is a tiny 8-bit accumulator processor meant to be stamped out many times as a simple compute node. It pulls one 16-bit instruction word per clock from a private code memory and reaches a separate 256-byte data memory through an 8-bit address. Its state is an accumulator A, an index register X, a square-high register H, the N, Z and C flags, and a program counter. Every instruction retires in one clock, because both memory ports are read combinationally. Those reads include a read-modify-write of a data byte and a squaring of a data byte.

Control flow uses only branches relative to the program counter. There is no absolute jump and no subroutine call. The logic-exclusive-OR slots of the familiar 8-bit opcode map are taken by a squaring instruction. That instruction leaves the low byte of the square in A and the high byte in H, which a transfer instruction then copies to A. A halt input freezes the core.

Top module: `nano_acc_core`

## Requirements
- R1: The core drives `imem_addr` with PC and decodes `imem_data` as opcode in bits [15:8] and operand in bits [7:0]. Every instruction completes in one clock, and PC advances by one unless a branch is taken.
- R2: Immediate forms use the operand byte as the value. Zero-page forms use the operand byte as the data address. Zero-page,X forms use operand+X modulo 256 as the data address.
- R3: The load, store and transfer opcodes are as follows. LDA uses A9 (immediate), A5 (zp) and B5 (zp,X). LDX uses A2 (immediate) and A6 (zp). STA uses 85 (zp) and 95 (zp,X), and STX uses 86 (zp). TAX is AA and TXA is 8A.
- R4: ADC is 69 (immediate), 65 (zp) and 75 (zp,X). It computes A+operand+C, writes the low 8 bits to A and sets C to bit 8. CLC (18) clears C and SEC (38) sets C.
- R5: AND is 29, 25 and 35, and ORA is 09, 05 and 15, with the same three forms as ADC. ASL A (0A) shifts left and moves bit 7 into C. LSR A (4A) shifts right and moves bit 0 into C.
- R6: CMP is C9 (immediate) and C5 (zp). It leaves A unchanged, sets C when A is greater than or equal to the operand (unsigned), and sets N and Z from A minus operand.
- R7: SQR is 49 (squares A), 45 (zp) and 55 (zp,X). It writes the low byte of the 16-bit square to A and the high byte to H, and leaves C unchanged. MVH (9B) copies H to A.
- R8: INX is E8 and DEX is CA. INC is E6 (zp) and DEC is C6 (zp), each a one-cycle read-modify-write. All four wrap modulo 256.
- R9: Every instruction that produces a register or memory result sets N to bit 7 of that result and Z when the result is zero. This covers loads, transfers, ADC, AND, ORA, shifts, SQR, MVH and the increment and decrement instructions. Stores, branches, CLC and SEC leave N and Z unchanged.
- R10: The branch opcodes are BPL 10, BMI 30, BCC 90, BCS B0, BNE D0, BEQ F0, and BRA 80 (always taken). A taken branch loads PC with PC+1 plus the sign-extended operand byte.
- R11: While `halt` is high, PC, A, X, H and the flags hold, and `dmem_we` stays low.
- R12: Any opcode not listed in R3 to R10 behaves as a no-operation (EA is the named one). It writes no register, flag or memory.
- R13: While `rst_n` is low, PC, A, X, H and the flags are cleared and `dmem_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Freezes the core while high |
| imem_addr | output | PC_W | Instruction address (PC) |
| imem_data | input | 16 | Instruction word read combinationally at `imem_addr` |
| dmem_addr | output | 8 | Data memory address |
| dmem_rdata | input | 8 | Data byte read combinationally at `dmem_addr` |
| dmem_wdata | output | 8 | Data byte to write |
| dmem_we | output | 1 | Write enable, sampled at the rising clock edge |

## Verification
Each instruction's effect is due at the rising edge that ends its fetch cycle. A store lands in the data memory on that same edge, and a register result is visible to the instruction fetched next. The bench therefore checks no internal register directly. Each program ends in a self-loop, and each test checks data memory only after the program has reached that loop. Test programs expose A, H and the C, Z and N flags through stores and flag-guarded stores. PC and the absence of writes are sampled at falling edges, half a cycle after the edge that changed them.

// File: rtl/nano_acc_core.sv
module nano_acc_core #(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  output logic [PC_W-1:0] imem_addr,
  input  logic [15:0]     imem_data,
  output logic [7:0]      dmem_addr,
  input  logic [7:0]      dmem_rdata,
  output logic [7:0]      dmem_wdata,
  output logic            dmem_we
);

  localparam logic [PC_W-1:0] PC_ONE = 1;

  logic [PC_W-1:0] pc, pc_n, pc_inc, br_off;
  logic [7:0]      acc, xr, hr, a_n, x_n, h_n, wd, res, opnd, sq_src;
  logic            n_q, z_q, c_q, n_n, z_n, c_n, we, upd, take;
  logic [7:0]      op, arg;
  logic            idx, imm;
  logic [8:0]      sum9, diff9;
  logic [15:0]     sq;

  assign op  = imem_data[15:8];
  assign arg = imem_data[7:0];

  assign idx = (op == 8'hB5) || (op == 8'h95) || (op == 8'h75) ||
               (op == 8'h35) || (op == 8'h15) || (op == 8'h55);
  assign imm = (op == 8'hA9) || (op == 8'hA2) || (op == 8'h69) ||
               (op == 8'h29) || (op == 8'h09) || (op == 8'hC9);

  assign dmem_addr = idx ? arg + xr : arg;
  assign opnd      = imm ? arg : dmem_rdata;

  assign sum9   = {1'b0, acc} + {1'b0, opnd} + {8'b0, c_q};
  assign diff9  = {1'b0, acc} - {1'b0, opnd};
  assign sq_src = (op == 8'h49) ? acc : dmem_rdata;
  assign sq     = {8'b0, sq_src} * {8'b0, sq_src};

  assign pc_inc = pc + PC_ONE;
  assign br_off = {{(PC_W-8){arg[7]}}, arg};

  always_comb begin
    a_n = acc; x_n = xr; h_n = hr;
    c_n = c_q; n_n = n_q; z_n = z_q;
    we = 1'b0; wd = acc; res = 8'h00; upd = 1'b0; take = 1'b0;
    case (op)
      8'hA9, 8'hA5, 8'hB5: begin a_n = opnd; res = opnd; upd = 1'b1; end
      8'hA2, 8'hA6:        begin x_n = opnd; res = opnd; upd = 1'b1; end
      8'h85, 8'h95:        begin we = 1'b1; wd = acc; end
      8'h86:               begin we = 1'b1; wd = xr; end
      8'hAA:               begin x_n = acc; res = acc; upd = 1'b1; end
      8'h8A:               begin a_n = xr; res = xr; upd = 1'b1; end
      8'h69, 8'h65, 8'h75: begin
        a_n = sum9[7:0]; c_n = sum9[8]; res = sum9[7:0]; upd = 1'b1;
      end
      8'h29, 8'h25, 8'h35: begin a_n = acc & opnd; res = acc & opnd; upd = 1'b1; end
      8'h09, 8'h05, 8'h15: begin a_n = acc | opnd; res = acc | opnd; upd = 1'b1; end
      8'h0A: begin a_n = {acc[6:0], 1'b0}; c_n = acc[7]; res = {acc[6:0], 1'b0}; upd = 1'b1; end
      8'h4A: begin a_n = {1'b0, acc[7:1]}; c_n = acc[0]; res = {1'b0, acc[7:1]}; upd = 1'b1; end
      8'hC9, 8'hC5:        begin c_n = ~diff9[8]; res = diff9[7:0]; upd = 1'b1; end
      8'h49, 8'h45, 8'h55: begin
        a_n = sq[7:0]; h_n = sq[15:8]; res = sq[7:0]; upd = 1'b1;
      end
      8'h9B:               begin a_n = hr; res = hr; upd = 1'b1; end
      8'hE8:               begin x_n = xr + 8'd1; res = xr + 8'd1; upd = 1'b1; end
      8'hCA:               begin x_n = xr - 8'd1; res = xr - 8'd1; upd = 1'b1; end
      8'hE6: begin we = 1'b1; wd = dmem_rdata + 8'd1; res = dmem_rdata + 8'd1; upd = 1'b1; end
      8'hC6: begin we = 1'b1; wd = dmem_rdata - 8'd1; res = dmem_rdata - 8'd1; upd = 1'b1; end
      8'h18: c_n = 1'b0;
      8'h38: c_n = 1'b1;
      8'h10: take = ~n_q;
      8'h30: take = n_q;
      8'h90: take = ~c_q;
      8'hB0: take = c_q;
      8'hD0: take = ~z_q;
      8'hF0: take = z_q;
      8'h80: take = 1'b1;
      default: ;
    endcase
    if (upd) begin
      n_n = res[7];
      z_n = (res == 8'h00);
    end
  end

  assign pc_n = take ? pc_inc + br_off : pc_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; acc <= '0; xr <= '0; hr <= '0;
      n_q <= 1'b0; z_q <= 1'b0; c_q <= 1'b0;
    end else if (!halt) begin
      pc <= pc_n; acc <= a_n; xr <= x_n; hr <= h_n;
      n_q <= n_n; z_q <= z_n; c_q <= c_n;
    end
  end

  assign imem_addr  = pc;
  assign dmem_wdata = wd;
  assign dmem_we    = we & ~halt & rst_n;

endmodule

// File: rtl/nano_acc_core_chk.sv
module nano_acc_core_chk #(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            halt,
  input logic [PC_W-1:0] imem_addr,
  input logic [15:0]     imem_data,
  input logic            dmem_we,
  input logic [7:0]      acc,
  input logic            c_q
);

  localparam logic [PC_W-1:0] ONE = 1;
  logic [PC_W-1:0] soff;
  logic [7:0]      opc;
  logic            is_sqr;

  assign opc    = imem_data[15:8];
  assign soff   = {{(PC_W-8){imem_data[7]}}, imem_data[7:0]};
  assign is_sqr = (opc == 8'h49) || (opc == 8'h45) || (opc == 8'h55);

  a_r11_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> imem_addr == $past(imem_addr));

  a_r11_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !dmem_we);

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && opc == 8'hEA) |=> imem_addr == $past(imem_addr) + ONE);

  a_r10_bra_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && opc == 8'h80) |=> imem_addr == $past(imem_addr) + ONE + $past(soff));

  a_r7_sqr_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && is_sqr) |=> c_q == $past(c_q));

  a_r6_cmp_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && (opc == 8'hC9 || opc == 8'hC5)) |=> acc == $past(acc));

endmodule

bind nano_acc_core nano_acc_core_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .imem_addr(imem_addr),
  .imem_data(imem_data), .dmem_we(dmem_we), .acc(acc), .c_q(c_q)
);

// File: tb/nano_acc_core_test.sv
module nano_acc_core_test;
  localparam int PC_W = 10;
  localparam int NV = 15;
  // {opcode, A preload, operand value, carry in, expected A, {0,C,Z,N}, expected H}
  localparam logic [47:0] VEC [NV] = '{
    48'hA9_00_80_0_80_1_00, 48'h69_50_30_1_81_1_00, 48'h69_FF_01_0_00_6_00,
    48'h65_10_20_1_31_0_00, 48'h75_80_90_0_10_4_00, 48'h29_F0_0F_1_00_6_00,
    48'h09_80_01_0_81_1_00, 48'hC9_40_40_0_40_6_00, 48'hC9_10_20_1_10_1_00,
    48'h49_0F_00_0_E1_1_00, 48'h45_00_FF_1_01_4_FE, 48'h55_00_10_0_00_2_01,
    48'h49_80_00_0_00_2_40, 48'h0A_81_00_0_02_4_00, 48'h4A_01_00_0_00_6_00
  };

  logic clk = 1'b0, rst_n = 1'b0, halt = 1'b0;
  logic [PC_W-1:0] imem_addr;
  logic [15:0] imem_data;
  logic [7:0] dmem_addr, dmem_rdata, dmem_wdata;
  logic dmem_we;
  logic [15:0] imem [1024];
  logic [7:0]  dmem [256];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  nano_acc_core #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .imem_addr(imem_addr),
    .imem_data(imem_data), .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
    .dmem_wdata(dmem_wdata), .dmem_we(dmem_we)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_reset(input logic [7:0] fill);
    @(negedge clk);
    rst_n = 1'b0;
    halt  = 1'b0;
    for (int i = 0; i < 1024; i++) imem[i] = 16'h80FF;
    for (int i = 0; i < 256; i++) dmem[i] = fill;
  endtask

  task automatic go(input int cycles);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  function automatic string tag(input logic [7:0] op);
    case (op)
      8'hA9: return "R3";
      8'h69, 8'h65, 8'h75: return "R4";
      8'h29, 8'h09, 8'h0A, 8'h4A: return "R5";
      8'hC9: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    // table walk: flags captured with X=1 stores guarded by branches
    for (int v = 0; v < NV; v++) begin
      logic [7:0] op, a, b, ea, eh, arg;
      logic cin;
      logic [3:0] fl;
      {op, a, b} = VEC[v][47:24];
      cin = VEC[v][20];
      {ea, fl, eh} = VEC[v][19:0];
      arg = (op == 8'h65 || op == 8'h45) ? 8'h30 :
            (op == 8'h75 || op == 8'h55) ? 8'h2F : b;   // R2 zp and zp,X forms
      hold_reset(8'h00);
      dmem[8'h30] = b;
      imem[0]  = 16'hA201;
      imem[1]  = {8'hA9, a};
      imem[2]  = cin ? 16'h3800 : 16'h1800;
      imem[3]  = {op, arg};
      imem[4]  = 16'h8510;
      imem[5]  = 16'h9001;
      imem[6]  = 16'h8620;
      imem[7]  = 16'hD001;
      imem[8]  = 16'h8621;
      imem[9]  = 16'h1001;
      imem[10] = 16'h8622;
      imem[11] = 16'h9B00;
      imem[12] = 16'h8511;
      go(20);
      chk({tag(op), " result A"}, {8'h0, dmem[8'h10]}, {8'h0, ea});
      chk("R7 high byte via MVH", {8'h0, dmem[8'h11]}, {8'h0, eh});
      chk({tag(op), " carry"}, {8'h0, dmem[8'h20]}, {15'h0, fl[2]});
      chk("R9 zero flag", {8'h0, dmem[8'h21]}, {15'h0, fl[1]});
      chk("R9 negative flag", {8'h0, dmem[8'h22]}, {15'h0, fl[0]});
    end

    // R13 reset state: a store at address 0 must not write during reset
    hold_reset(8'hAA);
    imem[0] = 16'h8510; imem[1] = 16'h8611; imem[2] = 16'h9B00; imem[3] = 16'h8512;
    @(negedge clk);
    chk("R13 pc in reset", {6'h0, imem_addr}, 16'h0);
    chk("R13 no write in reset", {15'h0, dmem_we}, 16'h0);
    go(1);
    chk("R1 pc steps by one", {6'h0, imem_addr}, 16'h1);
    repeat (6) @(negedge clk);
    chk("R13 A cleared", {8'h0, dmem[8'h10]}, 16'h0);
    chk("R13 X cleared", {8'h0, dmem[8'h11]}, 16'h0);
    chk("R13 H cleared", {8'h0, dmem[8'h12]}, 16'h0);

    // R10 backward loop, R8 DEX wrap, R3 TXA
    hold_reset(8'h00);
    imem[0] = 16'hA203; imem[1] = 16'hCA00; imem[2] = 16'hD0FE; imem[3] = 16'h8640;
    imem[4] = 16'hCA00; imem[5] = 16'h8641; imem[6] = 16'h8A00; imem[7] = 16'h8542;
    go(20);
    chk("R10 loop exit X", {8'h0, dmem[8'h40]}, 16'h0);
    chk("R8 DEX wraps", {8'h0, dmem[8'h41]}, 16'h00FF);
    chk("R3 TXA", {8'h0, dmem[8'h42]}, 16'h00FF);

    // R2 zp,X wrap, R8 INC/DEC zero page
    hold_reset(8'h00);
    dmem[8'h00] = 8'h07;
    imem[0] = 16'hA201; imem[1] = 16'hA95A; imem[2] = 16'h95FF; imem[3] = 16'hE600;
    imem[4] = 16'hC650; imem[5] = 16'hB5FF; imem[6] = 16'h8551;
    go(16);
    chk("R8 INC zp", {8'h0, dmem[8'h00]}, 16'h005B);
    chk("R8 DEC zp wraps", {8'h0, dmem[8'h50]}, 16'h00FF);
    chk("R2 zp,X wraps", {8'h0, dmem[8'h51]}, 16'h005B);

    // R12 unknown opcode, R10 branch not taken
    hold_reset(8'h00);
    imem[0] = 16'hA933; imem[1] = 16'hFF72; imem[2] = 16'h8570; imem[3] = 16'hF001;
    imem[4] = 16'h8571;
    go(12);
    chk("R12 unknown opcode keeps A", {8'h0, dmem[8'h70]}, 16'h0033);
    chk("R12 unknown opcode writes nothing", {8'h0, dmem[8'h72]}, 16'h0);
    chk("R10 BEQ not taken", {8'h0, dmem[8'h71]}, 16'h0033);

    // R11 halt
    hold_reset(8'h00);
    imem[0] = 16'hA200; imem[1] = 16'hE800; imem[2] = 16'h8660; imem[3] = 16'h80FD;
    go(7);
    begin
      logic [PC_W-1:0] held_pc;
      logic [7:0] held_val;
      logic saw_we;
      halt = 1'b1;
      @(negedge clk);
      held_pc = imem_addr; held_val = dmem[8'h60]; saw_we = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (dmem_we) saw_we = 1'b1;
      end
      chk("R11 pc frozen", {6'h0, imem_addr}, {6'h0, held_pc});
      chk("R11 no write while halted", {15'h0, saw_we}, 16'h0);
      chk("R11 memory untouched", {8'h0, dmem[8'h60]}, {8'h0, held_val});
      halt = 1'b0;
      repeat (6) @(negedge clk);
      chk("R11 resumes", {15'h0, dmem[8'h60] != held_val}, 16'h1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule